// File: doc/BRIEF.md
# H-Bridge Fault Guard

This block is the control and protection logic for one power stage built from two half-bridges, side A and side B. Each side is commanded by a complementary PWM pair. The block also takes two active-low control pins and four sampled fault flags: over-current, over-temperature trip, high-temperature warning and low regulator voltage. For each half-bridge output it produces a command to drive high, drive low or float. It also produces an active-low run flag and a two-bit error code, which together form a three-bit status word.

Every pin passes through a two-flop synchronizer. The synchronized values are decoded by one priority tree, and the results are registered.

- Over-current latches the bridge in the floating state until the mute pin is asserted.
- Illegal PWM pairs, over-temperature and low regulator voltage pull both outputs low only while the condition lasts.
- Over-temperature has hysteresis: once tripped, it stays active until the warning flag also drops.
- A PWM pair that stops toggling is treated as an illegal pair. The idle window is set through a configuration input.

Top module: `hb_guard`

## Requirements
- R1: While `rst` is high, both output commands read 2'b10 (float) and the status word {`shut_n`,`err_code`} reads 3'b111. Output commands are encoded as 2'b00 low, 2'b01 high, 2'b10 float.
- R2: When `park_n` is low, both outputs float and the status reads 3'b111. This holds whatever the mute pin, the PWM pins or the fault flags are doing.
- R3: When `mute_n` is low and `park_n` is high, the PWM pins are ignored, both outputs are low and the status reads 3'b111. Mute also clears the over-current latch.
- R4: In normal operation a pair with p=1, m=0 drives that side high, and a pair with p=0, m=1 drives it low. The status reads 3'b111.
- R5: A pair with p equal to m (00 or 11) on either side forces both outputs low with status 3'b000. Operation returns to normal as soon as a legal pair is applied again.
- R6: A low regulator flag forces both outputs low with status 3'b011. Normal operation resumes when the flag drops.
- R7: The warning flag alone leaves the outputs decoding normally and sets the status to 3'b110.
- R8: The over-temperature flag forces both outputs low with status 3'b010. After that flag drops, the condition persists while the warning flag stays high, and clears once the warning flag drops.
- R9: The over-current flag floats both outputs with status 3'b001. This state persists after the flag drops, until mute is asserted.
- R10: When several faults are active, the status follows this priority: short (001), then illegal pair (000), then over-temperature (010), then low regulator (011), then warning (110). With `shut_n` high, the error code is never 00 or 01.
- R11: If a PWM pair shows no edge for `idle_lim` system clocks while the block is neither parked nor muted, the pair counts as illegal (status 3'b000). The first edge afterwards restores normal operation.
- R12: A pair toggling at 97% duty, with a period shorter than the idle window, never raises a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_lim | input | CNT_W | Clocks without a PWM edge before a pair is judged stopped |
| park_n | input | 1 | Power-down, active low; overrides everything |
| mute_n | input | 1 | Mute and latch clear, active low |
| pwm_a_p | input | 1 | Side A positive PWM |
| pwm_a_m | input | 1 | Side A negative PWM |
| pwm_b_p | input | 1 | Side B positive PWM |
| pwm_b_m | input | 1 | Side B negative PWM |
| oc_flag | input | 1 | Over-current sense |
| ot_flag | input | 1 | Over-temperature trip sense |
| warn_flag | input | 1 | High-temperature warning sense |
| uv_flag | input | 1 | Low regulator voltage sense |
| out_a | output | 2 | Side A command: 00 low, 01 high, 10 float |
| out_b | output | 2 | Side B command, same encoding |
| shut_n | output | 1 | Low while a fault disables the bridge |
| err_code | output | 2 | Error code, the low two bits of the status word |

## Verification
A pin change driven between edges reaches the first synchronizer flop at the next rising edge and the second flop one edge later. The registered outputs reflect it at the third edge, so the bench's driver waits three rising edges before queuing each expected item. A monitor compares queued items at the following falling edge.

Recovery from a stopped pair takes one edge more, because the idle counter is registered ahead of the output stage; that step waits four edges.

The stopped-input check waits well past the idle window. The duty-cycle run queues a status-only item after every cycle, so any transient fault during toggling is caught.

// File: rtl/hb_guard_pkg.sv
package hb_guard_pkg;

    typedef enum logic [1:0] {
        DRV_LO = 2'b00,
        DRV_HI = 2'b01,
        DRV_Z  = 2'b10
    } drv_e;

    typedef struct packed {
        logic p;
        logic m;
    } pair_t;

    // status word {run, code}
    localparam logic [2:0] ST_BADIN = 3'b000;
    localparam logic [2:0] ST_SHORT = 3'b001;
    localparam logic [2:0] ST_HOT   = 3'b010;
    localparam logic [2:0] ST_LOWV  = 3'b011;
    localparam logic [2:0] ST_WARN  = 3'b110;
    localparam logic [2:0] ST_OK    = 3'b111;

    function automatic drv_e pair_drive(pair_t x);
        return x.p ? DRV_HI : DRV_LO;
    endfunction

    function automatic logic pair_bad(pair_t x);
        return x.p == x.m;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hb_activity.sv
module hb_activity
    import hb_guard_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  pair_t            pin,
    input  logic [CNT_W-1:0] idle_lim,
    output logic             bad
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    pair_t            prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             edge_seen;

    assign edge_seen = (pin.p ^ prev_q.p) | (pin.m ^ prev_q.m);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else begin
            prev_q <= pin;
            if (clr || edge_seen)     cnt_q <= '0;
            else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign bad = pair_bad(pin) | (cnt_q >= idle_lim);

    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!clr && !edge_seen && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R11
    AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> (cnt_q == '0)); // R11
endmodule

// File: rtl/hb_fault.sv
module hb_fault (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic oc,
    input  logic ot,
    input  logic warn,
    output logic short_act,
    output logic hot_act
);
    logic oc_q;
    logic hot_q;

    assign short_act = oc | oc_q;
    assign hot_act   = ot | (hot_q & warn);

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_q  <= 1'b0;
            hot_q <= 1'b0;
        end else begin
            oc_q  <= clr ? 1'b0 : short_act;
            hot_q <= hot_act;
        end
    end

    AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (oc_q && !clr) |=> oc_q); // R9
    AST_HOT_HYST: assert property (@(posedge clk) disable iff (rst)
        (hot_q && warn) |-> hot_act); // R8
    AST_HOT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!ot && !warn) |=> !hot_q); // R8
endmodule

// File: rtl/hb_guard.sv
module hb_guard
    import hb_guard_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] idle_lim,
    input  logic             park_n,
    input  logic             mute_n,
    input  logic             pwm_a_p,
    input  logic             pwm_a_m,
    input  logic             pwm_b_p,
    input  logic             pwm_b_m,
    input  logic             oc_flag,
    input  logic             ot_flag,
    input  logic             warn_flag,
    input  logic             uv_flag,
    output logic [1:0]       out_a,
    output logic [1:0]       out_b,
    output logic             shut_n,
    output logic [1:0]       err_code
);
    localparam int SIDES  = 2;
    localparam int SYNC_W = 2 + 2 * SIDES + 4;

    logic [SYNC_W-1:0] raw, syn;
    pair_t             pair_s [SIDES];
    logic              bad_s  [SIDES];
    logic              park_s, mute_s, oc_s, ot_s, warn_s, uv_s;
    logic              clr, short_act, hot_act, any_bad;

    drv_e       nxt_a, nxt_b, drv_a_q, drv_b_q;
    logic [2:0] nxt_st, st_q;

    assign raw = {park_n, mute_n, pwm_a_p, pwm_a_m, pwm_b_p, pwm_b_m,
                  oc_flag, ot_flag, warn_flag, uv_flag};

    hb_sync #(.W(SYNC_W), .STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    // pins synchronize as 0 in reset, so the block starts parked
    assign park_s      = ~syn[9];
    assign mute_s      = ~syn[8];
    assign pair_s[0].p = syn[7];
    assign pair_s[0].m = syn[6];
    assign pair_s[1].p = syn[5];
    assign pair_s[1].m = syn[4];
    assign oc_s        = syn[3];
    assign ot_s        = syn[2];
    assign warn_s      = syn[1];
    assign uv_s        = syn[0];

    assign clr = park_s | mute_s;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        hb_activity #(.CNT_W(CNT_W)) i_act (
            .clk(clk), .rst(rst), .clr(clr), .pin(pair_s[s]),
            .idle_lim(idle_lim), .bad(bad_s[s])
        );
    end

    always_comb begin
        any_bad = 1'b0;
        for (int s = 0; s < SIDES; s++) any_bad = any_bad | bad_s[s];
    end

    hb_fault i_fault (
        .clk(clk), .rst(rst), .clr(clr), .oc(oc_s), .ot(ot_s), .warn(warn_s),
        .short_act(short_act), .hot_act(hot_act)
    );

    always_comb begin
        nxt_a  = DRV_LO;
        nxt_b  = DRV_LO;
        nxt_st = ST_OK;
        if (park_s) begin
            nxt_a = DRV_Z;
            nxt_b = DRV_Z;
        end else if (mute_s) begin
            nxt_st = ST_OK;
        end else if (short_act) begin
            nxt_a  = DRV_Z;
            nxt_b  = DRV_Z;
            nxt_st = ST_SHORT;
        end else if (any_bad) begin
            nxt_st = ST_BADIN;
        end else if (hot_act) begin
            nxt_st = ST_HOT;
        end else if (uv_s) begin
            nxt_st = ST_LOWV;
        end else begin
            nxt_a  = pair_drive(pair_s[0]);
            nxt_b  = pair_drive(pair_s[1]);
            nxt_st = warn_s ? ST_WARN : ST_OK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_a_q <= DRV_Z;
            drv_b_q <= DRV_Z;
            st_q    <= ST_OK;
        end else begin
            drv_a_q <= nxt_a;
            drv_b_q <= nxt_b;
            st_q    <= nxt_st;
        end
    end

    assign out_a    = drv_a_q;
    assign out_b    = drv_b_q;
    assign shut_n   = st_q[2];
    assign err_code = st_q[1:0];

    AST_PARK_FLOAT: assert property (@(posedge clk) disable iff (rst)
        park_s |=> (drv_a_q == DRV_Z && drv_b_q == DRV_Z && st_q == ST_OK)); // R2
    AST_MUTE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!park_s && mute_s) |=> (drv_a_q == DRV_LO && drv_b_q == DRV_LO && st_q == ST_OK)); // R3
    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
        st_q[2] |-> st_q[1]); // R10
    AST_FLOAT_ONLY_SAFE: assert property (@(posedge clk) disable iff (rst)
        (drv_a_q == DRV_Z) |-> (st_q == ST_SHORT || st_q == ST_OK)); // R9
    AST_FAULT_NOT_HIGH: assert property (@(posedge clk) disable iff (rst)
        !st_q[2] |-> (drv_a_q != DRV_HI && drv_b_q != DRV_HI)); // R5
endmodule

// File: tb/test_hb_guard.sv
`timescale 1ns/1ps
module test_hb_guard;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] idle_lim = 16'd1000;
    logic             park_n = 1'b0, mute_n = 1'b0;
    logic             pa = 1'b1, ma = 1'b0, pb = 1'b0, mb = 1'b1;
    logic             oc = 1'b0, ot = 1'b0, warn = 1'b0, uv = 1'b0;
    logic [1:0]       out_a, out_b, err_code;
    logic             shut_n;

    localparam logic [1:0] LO = 2'b00, HI = 2'b01, FZ = 2'b10;

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        logic [2:0] st;
        bit         chk_drv;
        string      tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    always #4 clk = ~clk;

    hb_guard #(.CNT_W(CNT_W)) i_hb_guard (
        .clk(clk), .rst(rst), .idle_lim(idle_lim), .park_n(park_n), .mute_n(mute_n),
        .pwm_a_p(pa), .pwm_a_m(ma), .pwm_b_p(pb), .pwm_b_m(mb),
        .oc_flag(oc), .ot_flag(ot), .warn_flag(warn), .uv_flag(uv),
        .out_a(out_a), .out_b(out_b), .shut_n(shut_n), .err_code(err_code)
    );

    // monitor: compare the oldest expectation at each falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if ({shut_n, err_code} !== it.st ||
                (it.chk_drv && (out_a !== it.a || out_b !== it.b))) begin
                errors++;
                $display("FAIL %s: got a=%b b=%b st=%b, expected a=%b b=%b st=%b",
                         it.tag, out_a, out_b, {shut_n, err_code}, it.a, it.b, it.st);
            end
        end
    end

    task automatic push(input logic [1:0] a, input logic [1:0] b, input logic [2:0] st,
                        input bit chk_drv, input string tag);
        item_t it;
        it.a = a; it.b = b; it.st = st; it.chk_drv = chk_drv; it.tag = tag;
        sb.push_back(it);
    endtask

    // called at a falling edge after inputs changed; result due at third rising edge
    task automatic expect_after(input int extra, input logic [1:0] a, input logic [1:0] b,
                                input logic [2:0] st, input string tag);
        repeat (3 + extra) @(posedge clk);
        push(a, b, st, 1'b1, tag);
        @(negedge clk);
    endtask

    task automatic set_pwm(input logic a_p, input logic a_m, input logic b_p, input logic b_m);
        pa = a_p; ma = a_m; pb = b_p; mb = b_m;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        push(FZ, FZ, 3'b111, 1'b1, "R1 reset state");
        @(negedge clk);
        rst = 1'b0;

        // R2: park overrides mute released and an active fault
        park_n = 0; mute_n = 1; oc = 1;
        expect_after(0, FZ, FZ, 3'b111, "R2 park precedence");

        // R3: mute ignores PWM
        park_n = 1; mute_n = 0; oc = 0; set_pwm(1, 0, 0, 1);
        expect_after(0, LO, LO, 3'b111, "R3 mute ignores pwm");

        mute_n = 1;
        expect_after(0, HI, LO, 3'b111, "R4 decode a=10 b=01");
        set_pwm(0, 1, 1, 0);
        expect_after(0, LO, HI, 3'b111, "R4 decode a=01 b=10");

        set_pwm(1, 1, 1, 0);
        expect_after(0, LO, LO, 3'b000, "R5 pair 11");
        set_pwm(0, 0, 1, 0);
        expect_after(0, LO, LO, 3'b000, "R5 pair 00");
        set_pwm(1, 0, 0, 1);
        expect_after(0, HI, LO, 3'b111, "R5 self clear");

        uv = 1;
        expect_after(0, LO, LO, 3'b011, "R6 low regulator");
        uv = 0;
        expect_after(0, HI, LO, 3'b111, "R6 recover");

        warn = 1;
        expect_after(0, HI, LO, 3'b110, "R7 warning only");

        ot = 1;
        expect_after(0, LO, LO, 3'b010, "R8 over-temp trip");
        ot = 0;
        expect_after(0, LO, LO, 3'b010, "R8 hysteresis hold");
        warn = 0;
        expect_after(0, HI, LO, 3'b111, "R8 release");

        oc = 1;
        expect_after(0, FZ, FZ, 3'b001, "R9 short");
        oc = 0;
        expect_after(0, FZ, FZ, 3'b001, "R9 latched");
        mute_n = 0;
        expect_after(0, LO, LO, 3'b111, "R3 mute clears latch");
        mute_n = 1;
        expect_after(0, HI, LO, 3'b111, "R9 normal after clear");

        // R10 priorities
        oc = 1; set_pwm(1, 1, 0, 1);
        expect_after(0, FZ, FZ, 3'b001, "R10 short over illegal");
        oc = 0; mute_n = 0;
        expect_after(0, LO, LO, 3'b111, "R10 clear");
        mute_n = 1; ot = 1;
        expect_after(0, LO, LO, 3'b000, "R10 illegal over hot");
        set_pwm(1, 0, 0, 1); uv = 1;
        expect_after(0, LO, LO, 3'b010, "R10 hot over lowv");
        ot = 0;
        expect_after(0, LO, LO, 3'b011, "R10 lowv alone");
        warn = 1;
        expect_after(0, LO, LO, 3'b011, "R10 lowv over warning");
        uv = 0; warn = 0;
        expect_after(0, HI, LO, 3'b111, "R10 back to normal");

        // R11 lost clock
        mute_n = 0; idle_lim = 16'd20;
        expect_after(0, LO, LO, 3'b111, "R11 mute restart");
        mute_n = 1;
        expect_after(0, HI, LO, 3'b111, "R11 before window");
        expect_after(40, LO, LO, 3'b000, "R11 stopped pair");
        set_pwm(0, 1, 1, 0);
        expect_after(1, LO, HI, 3'b111, "R11 edge restores");

        // R12 97% duty, period 32, window 40
        idle_lim = 16'd40;
        for (int k = 0; k < 192; k++) begin
            logic hi;
            hi = ((k % 32) != 31);
            set_pwm(hi, ~hi, ~hi, hi);
            @(posedge clk);
            push(LO, LO, 3'b111, 1'b0, "R12 high duty stays active");
            @(negedge clk);
        end

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule